// File: doc/BRIEF.md
# SCL Clock Generator with Clock-Stretch Tolerance

This block produces the serial clock for an I2C master. It alternates between a low phase and a high phase. Each phase lasts a programmed number of counts. A count advances once every `clk_div` module clocks. The low phase is timed from the cycle in which the block starts pulling SCL low, so the programmed value has to cover the line's fall time as well. The high phase is timed only from the first cycle in which the sampled SCL line reads high. A slow rise, or a slave that holds the clock low, therefore lengthens the period instead of shortening the high time.

Each phase count is nine bits wide. The low eight bits come from one register per phase. The ninth bit of the low count is bit 7 of a shared extension register, and the ninth bit of the high count is bit 6 of that register. These two bits enter the block on their own pins.

When `run` is raised from idle, the block first times a full high phase with SCL released, which gives the START hold time, and then pulls SCL low. The byte engine can hold `hold` to keep SCL low between bytes. It clears `run` to park the clock released. One-cycle strobes mark each falling and rising edge of SCL.

Top module: `scl_stretch_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scl_oe` is 0 and both strobes are 0.
- R2: When `run` rises while the block is idle, SCL stays released and `rise_stb` pulses in the next cycle. SCL is then pulled low after the high phase, so the first high phase acts as the START hold time.
- R3: A low phase keeps `scl_oe` at 1 for exactly Nl × D cycles. Nl is the 9-bit value {`low_cnt_b8`, `low_cnt`}, where `low_cnt_b8` is bit 7 of the extension register. D is the effective divisor.
- R4: A high phase lasts exactly Nh × D cycles, counted from the `rise_stb` cycle up to the cycle before the next `fall_stb`. Nh is {`high_cnt_b8`, `high_cnt`}, where `high_cnt_b8` is bit 6 of the extension register. A count value of 0 behaves as 1.
- R5: High-phase counting does not start while the SCL input is sampled low. `rise_stb` pulses in the cycle after SCL is first sampled high, and only while SCL is released.
- R6: The effective divisor D equals `clk_div`, except that a `clk_div` of 0 behaves as 1.
- R7: While `hold` is 1 during a low phase, SCL stays pulled low. Once `hold` returns to 0 after the count has run out, SCL is released one cycle later (with D = 1).
- R8: After `run` is cleared, a low phase in progress still runs its full length. The clock then stays released with no further falling edge. Clearing `run` during a high phase parks SCL high at once.
- R9: `fall_stb` is 1 exactly in the first cycle of each low phase. `fall_stb` and `rise_stb` never pulse together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep generating clock pulses while 1 |
| hold | input | 1 | Keep SCL low at the end of the current low phase |
| low_cnt | input | BASE_W | Low-phase count, bits 7:0 |
| low_cnt_b8 | input | 1 | Low-phase count bit 8 (extension register bit 7) |
| high_cnt | input | BASE_W | High-phase count, bits 7:0 |
| high_cnt_b8 | input | 1 | High-phase count bit 8 (extension register bit 6) |
| clk_div | input | DIV_W | Module clocks per count (0 acts as 1) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | One-cycle strobe on each SCL falling edge |
| rise_stb | output | 1 | One-cycle strobe when released SCL is first seen high |

## Verification
The bound checker enforces several properties on every cycle:
- the falling strobe coincides with the start of each drive-low;
- the two strobes are exclusive;
- `rise_stb` only follows a high sample of SCL while SCL is released;
- `hold` never lets SCL go;
- a released clock with `run` low stays released;
- no new falling edge appears without `run`.

The exact phase lengths can only be shown by the directed scenarios, because they depend on the programmed counts, the ninth bits, the divisor and the zero-count rule. The same applies to the way a stretching slave or a `hold` lengthens a period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;

   localparam int SEL_LOW  = 0;
   localparam int SEL_HIGH = 1;
   localparam int N_PHASES = 2;

endpackage

// File: rtl/scl_count_assemble.sv
// Joins the byte-wide count with its ninth bit and maps 0 to 1.
module scl_count_assemble #(
   parameter int BASE_W = 8,
   localparam int CNT_W = BASE_W + 1
) (
   input  logic [BASE_W-1:0] base,
   input  logic              msb,
   output logic [CNT_W-1:0]  limit
);
   logic [CNT_W-1:0] raw;

   assign raw   = {msb, base};
   assign limit = (raw == '0) ? CNT_W'(1) : raw;
endmodule

// File: rtl/scl_prescaler.sv
// Issues one tick per DIV module clocks while enabled; restarts on clear.
module scl_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] last;

   assign last = (div == '0) ? '0 : div - DIV_W'(1);
   assign tick = en && (pcnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (clr || !en || tick)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/scl_phase_timer.sv
// Counts ticks within one phase; saturates at the limit while held.
module scl_phase_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             stall,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] end_val;
   logic             at_end;

   assign end_val = limit - CNT_W'(1);
   assign at_end  = (cnt_q >= end_val);
   assign done    = tick && at_end && !stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick && !at_end)
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/scl_stretch_gen.sv
module scl_stretch_gen
   import scl_gen_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              hold,
   input  logic [BASE_W-1:0] low_cnt,
   input  logic              low_cnt_b8,
   input  logic [BASE_W-1:0] high_cnt,
   input  logic              high_cnt_b8,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              scl_in,
   output logic              scl_oe,
   output logic              fall_stb,
   output logic              rise_stb
);
   localparam int CNT_W = BASE_W + 1;

   generate
      if (BASE_W < 1) begin : g_bad_base
         $error("BASE_W must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   phase_e state_q, state_n;
   logic   scl_s_q;
   logic   seen_hi_q;
   logic   fall_q;
   logic   phase_clr;
   logic   presc_en;
   logic   tick;
   logic   done;
   logic   stall;

   logic [N_PHASES-1:0][BASE_W-1:0] base_v;
   logic [N_PHASES-1:0]             msb_v;
   logic [N_PHASES-1:0][CNT_W-1:0]  lim_v;
   logic [CNT_W-1:0]                cur_lim;

   assign base_v[SEL_LOW]  = low_cnt;
   assign base_v[SEL_HIGH] = high_cnt;
   assign msb_v[SEL_LOW]   = low_cnt_b8;
   assign msb_v[SEL_HIGH]  = high_cnt_b8;

   for (genvar g = 0; g < N_PHASES; g++) begin : g_lim
      scl_count_assemble #(.BASE_W(BASE_W)) u_asm (
         .base  (base_v[g]),
         .msb   (msb_v[g]),
         .limit (lim_v[g])
      );
   end

   assign cur_lim  = (state_q == PH_LOW) ? lim_v[SEL_LOW] : lim_v[SEL_HIGH];
   assign presc_en = (state_q == PH_LOW) || ((state_q == PH_HIGH) && scl_s_q);
   assign stall    = (state_q == PH_LOW) && hold;

   scl_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (presc_en),
      .clr   (phase_clr),
      .div   (clk_div),
      .tick  (tick)
   );

   scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .tick  (tick),
      .stall (stall),
      .limit (cur_lim),
      .done  (done)
   );

   always_comb begin
      state_n = state_q;
      case (state_q)
         PH_IDLE: if (run) state_n = PH_HIGH;
         PH_HIGH: begin
            if (!run)      state_n = PH_IDLE;
            else if (done) state_n = PH_LOW;
         end
         PH_LOW:  if (done) state_n = PH_HIGH;
         default: state_n = PH_IDLE;
      endcase
   end

   assign phase_clr = (state_n != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PH_IDLE;
         scl_s_q   <= 1'b1;
         seen_hi_q <= 1'b0;
         fall_q    <= 1'b0;
      end else begin
         state_q <= state_n;
         scl_s_q <= scl_in;
         fall_q  <= (state_n == PH_LOW) && (state_q != PH_LOW);
         if (phase_clr)
            seen_hi_q <= 1'b0;
         else if (rise_stb)
            seen_hi_q <= 1'b1;
      end
   end

   assign scl_oe   = (state_q == PH_LOW);
   assign fall_stb = fall_q;
   assign rise_stb = (state_q == PH_HIGH) && scl_s_q && !seen_hi_q;
endmodule

// File: rtl/scl_stretch_gen_chk.sv
module scl_stretch_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic hold,
   input logic scl_in,
   input logic scl_oe,
   input logic fall_stb,
   input logic rise_stb
);
   p_fall_at_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> fall_stb);

   p_fall_only_at_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (scl_oe && !$past(scl_oe)));

   p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_stb && rise_stb));

   p_rise_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> ($past(scl_in) && !scl_oe));

   p_hold_keeps_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && hold) |=> scl_oe);

   p_parked_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !scl_oe) |=> !scl_oe);

   p_fall_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> $past(run));
endmodule

bind scl_stretch_gen scl_stretch_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .hold     (hold),
   .scl_in   (scl_in),
   .scl_oe   (scl_oe),
   .fall_stb (fall_stb),
   .rise_stb (rise_stb)
);

// File: tb/tb_scl_stretch_gen.sv
`timescale 1ns/1ps
module tb_scl_stretch_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       hold = 1'b0;
   logic [7:0] low_cnt = 8'd1;
   logic       low_cnt_b8 = 1'b0;
   logic [7:0] high_cnt = 8'd1;
   logic       high_cnt_b8 = 1'b0;
   logic [7:0] clk_div = 8'd1;
   logic       slave_low = 1'b0;
   logic       scl_in;
   logic       scl_oe, fall_stb, rise_stb;
   int         nchk = 0;
   int         nfail = 0;
   bit         finished = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_in = !scl_oe && !slave_low;

   scl_stretch_gen dut (
      .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
      .low_cnt(low_cnt), .low_cnt_b8(low_cnt_b8),
      .high_cnt(high_cnt), .high_cnt_b8(high_cnt_b8),
      .clk_div(clk_div), .scl_in(scl_in),
      .scl_oe(scl_oe), .fall_stb(fall_stb), .rise_stb(rise_stb)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int lo, input int hi, input int dv);
      low_cnt     = lo[7:0];
      low_cnt_b8  = lo[8];
      high_cnt    = hi[7:0];
      high_cnt_b8 = hi[8];
      clk_div     = dv[7:0];
   endtask

   // Returns the number of negedges waited until rise_stb is seen.
   task automatic wait_rise(output int n);
      n = 0;
      while (!rise_stb && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // Starting at the rise cycle, counts cycles up to the next fall_stb.
   task automatic high_len(output int n);
      n = 0;
      while (!fall_stb && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // Starting at the fall cycle, counts cycles with SCL pulled low.
   task automatic low_len(output int n);
      n = 0;
      while (scl_oe && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic park(input string req);
      int w;
      int falls;
      wait_rise(w);
      run = 1'b0;
      falls = 0;
      repeat (40) begin
         @(negedge clk);
         if (fall_stb) falls++;
      end
      check_eq({req, " no fall after stop"}, falls, 0);
      check_eq({req, " scl parked released"}, scl_oe, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check_eq("R1 scl_oe in reset", scl_oe, 0);
      check_eq("R1 strobes in reset", fall_stb + rise_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 scl_oe after reset", scl_oe, 0);
      check_eq("R1 strobes after reset", fall_stb + rise_stb, 0);
   endtask

   task automatic t_basic;
      int w, h1, l, h2;
      cfg(5, 4, 1);
      run = 1'b1;
      @(negedge clk);
      wait_rise(w);
      check_eq("R2 rise right after run", w, 0);
      check_eq("R2 released during start hold", scl_oe, 0);
      high_len(h1);
      check_eq("R2 start hold length", h1, 4);
      check_eq("R9 fall marks drive low", scl_oe, 1);
      l = 0;
      n_first_after_fall();
      low_len(l);
      check_eq("R3 low length", l + 1, 5);
      wait_rise(w);
      high_len(h2);
      check_eq("R4 high length", h2, 4);
      low_len(l);
      park("R8");
   endtask

   // Steps one cycle past a fall and checks the strobe was single-cycle.
   task automatic n_first_after_fall;
      @(negedge clk);
      check_eq("R9 fall strobe one cycle", fall_stb, 0);
   endtask

   task automatic t_div(input int dv, input int lo, input int hi, input string req);
      int w, h, l;
      cfg(lo, hi, dv);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      low_len(l);
      wait_rise(w);
      high_len(h);
      check_eq({req, " low length"}, l, lo * ((dv == 0) ? 1 : dv));
      check_eq({req, " high length"}, h, hi * ((dv == 0) ? 1 : dv));
      low_len(l);
      park(req);
   endtask

   task automatic t_ninth_bit;
      int w, h, l;
      cfg(258, 257, 1);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      check_eq("R4 ninth bit high", h, 257);
      low_len(l);
      check_eq("R3 ninth bit low", l, 258);
      park("R8");
   endtask

   task automatic t_zero;
      int w, h, l;
      cfg(0, 0, 1);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      check_eq("R4 zero high count", h, 1);
      low_len(l);
      check_eq("R3 zero low count", l, 1);
      park("R8");
   endtask

   task automatic t_stretch;
      int w, h, l, rises, falls, drv;
      cfg(3, 4, 1);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      slave_low = 1'b1;
      low_len(l);
      check_eq("R3 low before stretch", l, 3);
      rises = 0; falls = 0; drv = 0;
      repeat (10) begin
         @(negedge clk);
         if (rise_stb) rises++;
         if (fall_stb) falls++;
         if (scl_oe) drv++;
      end
      check_eq("R5 no rise while held low", rises, 0);
      check_eq("R5 no fall while held low", falls + drv, 0);
      slave_low = 1'b0;
      @(negedge clk);
      check_eq("R5 rise one cycle after release", rise_stb, 1);
      high_len(h);
      check_eq("R5 full high after stretch", h, 4);
      low_len(l);
      park("R8");
   endtask

   task automatic t_hold;
      int w, h, l, rel;
      cfg(3, 2, 1);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      hold = 1'b1;
      rel = 0;
      repeat (30) begin
         @(negedge clk);
         if (!scl_oe) rel++;
      end
      check_eq("R7 scl kept low by hold", rel, 0);
      hold = 1'b0;
      @(negedge clk);
      check_eq("R7 release one cycle after hold", scl_oe, 0);
      park("R8");
   endtask

   task automatic t_stop_in_low;
      int w, h, l, falls;
      cfg(6, 2, 1);
      run = 1'b1;
      wait_rise(w);
      high_len(h);
      run = 1'b0;
      low_len(l);
      check_eq("R8 low completes after stop", l, 6);
      falls = 0;
      repeat (40) begin
         @(negedge clk);
         if (fall_stb) falls++;
      end
      check_eq("R8 no fall after stop in low", falls, 0);
      check_eq("R8 parked released", scl_oe, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_div(3, 3, 2, "R6 div3");
      t_div(0, 4, 3, "R6 div0");
      t_ninth_bit();
      t_zero();
      t_stretch();
      t_hold();
      t_stop_in_low();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule